// File: doc/BRIEF.md
# Half-Bridge Restart Sequencer

This block decides when a half-bridge power stage may switch. Four status bits from analog circuits enter on a free-running clock: a supply-good flag, a raw under-voltage comparator on the bulk-sense pin, a raw over-threshold comparator used as a stop input, and a thermal-fault flag. The block deglitches the comparators and times a forced-sink check window and a fixed restart delay. It drives a gate-drive enable, the control of the current sink on the bulk-sense pin, a request that holds the oscillator and grounds its timing and soft-start nodes, and a status flag that reports the bulk level as good.

After every supply-up the sink is forced on for a check window, so that the sense node settles. The block then waits for a good bulk level, runs the restart delay with the oscillator held, and releases the drivers. A bulk brown-out stops switching, and its recovery runs the restart delay again. The stop input acts at once and, when released, lets switching resume with no delay. All lengths come from a clock-frequency parameter, and one bit selects the long or short timing set.

Top module: `hb_restart_seq`

## Requirements
- R1: After the supply flag rises, `bo_sink_o` is high for a check window of 50 ms (long set) or 6.3 ms (short set), whatever the bulk comparator reports. With the bulk good, the sink falls exactly window+1 clock edges after the supply rise.
- R2: If the filtered bulk comparator is low when the window ends, the sink stays on and `bo_ok_o` stays low. When the level later turns good, the sink falls after the filter time plus one edge.
- R3: The bulk comparator (1 = level good) passes a 20 µs deglitch counter. A pulse shorter than that has no effect on `drv_en_o`. A held change reaches the sequencer state filter-time+1 edges after it appears.
- R4: The restart delay (100 ms long set, 12.6 ms short set) starts when the bulk turns good after supply-up or after a recovery. `drv_en_o` rises exactly delay edges after `bo_ok_o` rises.
- R5: `osc_hold_o` is high from reset until switching is allowed, which covers the whole restart delay. It falls on the same edge on which `drv_en_o` can first rise.
- R6: `bo_ok_o` is high during the restart delay and while running, and `bo_sink_o` is low whenever `bo_ok_o` is high.
- R7: The stop comparator (1 = over threshold) passes a 0.5 µs deglitch counter (at least one clock). Once it is filtered high, `drv_en_o` falls. When it is released, `drv_en_o` returns after the filter time with no restart delay, and `osc_hold_o` stays low throughout.
- R8: A thermal fault or a low supply flag forces `drv_en_o` low in the same cycle. A supply loss sends the sequence back to its off state, with the sink on and `bo_ok_o` low.
- R9: A brown-out that reaches the state during the restart delay aborts it and restarts from the check window, so switching resumes window+delay edges later.
- R10: A brown-out while running drops `drv_en_o` and turns the sink on. On recovery only the restart delay runs, with no check window.
- R11: During and just after reset, `drv_en_o` and `bo_ok_o` are low and `bo_sink_o` and `osc_hold_o` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_ok_i | input | 1 | Supply above its operating level |
| bo_cmp_i | input | 1 | Raw bulk comparator, 1 = level good |
| en_cmp_i | input | 1 | Raw stop comparator, 1 = stop switching |
| therm_flt_i | input | 1 | Thermal fault, 1 = too hot |
| drv_en_o | output | 1 | Gate-drive enable |
| bo_sink_o | output | 1 | Bulk-sense current sink on |
| osc_hold_o | output | 1 | Hold oscillator, ground timing/soft-start nodes |
| bo_ok_o | output | 1 | Bulk level accepted |

## Verification
The bench builds two copies of the block, one for each timing set, both with a clock-frequency parameter of 100 kHz. This gives a 2-cycle bulk filter, a 1-cycle stop filter, check windows of 5000 and 630 cycles and restart delays of 10000 and 1260 cycles. At these sizes every window, delay and abort path of both sets can be run to its end and measured edge by edge against lengths the bench computes from the millisecond figures.

// File: rtl/hb_restart_seq_pkg.sv
package hb_restart_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_CHECK,
    ST_WAIT,
    ST_DELAY,
    ST_RUN
  } seq_st_e;

  // cycles = hz * num / den, at least one
  function automatic int unsigned cyc_of(longint unsigned hz, longint unsigned num,
                                         longint unsigned den);
    longint unsigned c;
    c = hz * num / den;
    return (c == 0) ? 1 : int'(c);
  endfunction

endpackage

// File: rtl/hb_deglitch.sv
module hb_deglitch #(
  parameter int unsigned LEN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned CW = (LEN < 2) ? 1 : $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;
  logic          q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else if (d_i == q_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(LEN - 1)) begin
      cnt_q <= '0;
      q_q   <= d_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/hb_seq_fsm.sv
module hb_seq_fsm
  import hb_restart_seq_pkg::*;
#(
  parameter int unsigned WIN_CYC = 5000,
  parameter int unsigned DLY_CYC = 10000
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    supply_ok_i,
  input  logic    bo_flt_i,
  output seq_st_e st_o
);
  localparam int unsigned MAX_CYC = (WIN_CYC > DLY_CYC) ? WIN_CYC : DLY_CYC;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  seq_st_e       st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_OFF;
      cnt_q <= '0;
    end else if (!supply_ok_i) begin
      st_q  <= ST_OFF;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          st_q  <= ST_CHECK;
          cnt_q <= CW'(WIN_CYC - 1);
        end
        ST_CHECK: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (bo_flt_i) begin
            st_q  <= ST_DELAY;
            cnt_q <= CW'(DLY_CYC - 1);
          end else begin
            st_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (bo_flt_i) begin
            st_q  <= ST_DELAY;
            cnt_q <= CW'(DLY_CYC - 1);
          end
        end
        ST_DELAY: begin
          // brown-out aborts the delay and re-runs the check window
          if (!bo_flt_i) begin
            st_q  <= ST_CHECK;
            cnt_q <= CW'(WIN_CYC - 1);
          end else if (cnt_q == '0) begin
            st_q <= ST_RUN;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_RUN: begin
          if (!bo_flt_i) st_q <= ST_WAIT;
        end
        default: st_q <= ST_OFF;
      endcase
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/hb_restart_seq.sv
module hb_restart_seq
  import hb_restart_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter bit          SHORT_VAR = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic bo_cmp_i,
  input  logic en_cmp_i,
  input  logic therm_flt_i,
  output logic drv_en_o,
  output logic bo_sink_o,
  output logic osc_hold_o,
  output logic bo_ok_o
);
  localparam longint unsigned HZ = longint'(CLK_HZ);
  localparam int unsigned WIN_CYC = SHORT_VAR ? cyc_of(HZ, 63, 10000) : cyc_of(HZ, 50, 1000);
  localparam int unsigned DLY_CYC = SHORT_VAR ? cyc_of(HZ, 126, 10000) : cyc_of(HZ, 1, 10);
  localparam int unsigned BO_FLT  = cyc_of(HZ, 20, 1_000_000);
  localparam int unsigned EN_FLT  = cyc_of(HZ, 1, 2_000_000);

  logic    bo_flt;
  logic    en_flt;
  seq_st_e st;

  hb_deglitch #(.LEN(BO_FLT)) u_bo_flt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bo_cmp_i),
    .q_o   (bo_flt)
  );

  hb_deglitch #(.LEN(EN_FLT)) u_en_flt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (en_cmp_i),
    .q_o   (en_flt)
  );

  hb_seq_fsm #(.WIN_CYC(WIN_CYC), .DLY_CYC(DLY_CYC)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .supply_ok_i(supply_ok_i),
    .bo_flt_i   (bo_flt),
    .st_o       (st)
  );

  // fault gating is combinational so drive stops in the same cycle
  assign drv_en_o   = (st == ST_RUN) && supply_ok_i && !therm_flt_i && !en_flt;
  assign bo_ok_o    = (st == ST_DELAY) || (st == ST_RUN);
  assign bo_sink_o  = !bo_ok_o;
  assign osc_hold_o = (st != ST_RUN);
endmodule

// File: rtl/hb_restart_seq_chk.sv
module hb_restart_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic supply_ok_i,
  input logic therm_flt_i,
  input logic drv_en_o,
  input logic bo_sink_o,
  input logic osc_hold_o,
  input logic bo_ok_o,
  input logic bo_flt,
  input logic en_flt
);
  // R1
  win_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(supply_ok_i) |=> bo_sink_o);

  // R3
  sink_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bo_sink_o) |-> bo_flt);

  // R4
  drv_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_en_o) |-> bo_ok_o);

  // R5
  delay_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bo_ok_o) |-> osc_hold_o);

  // R6
  sink_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bo_ok_o |-> !bo_sink_o);

  // R7
  en_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_en_o |-> !en_flt);

  // R8
  supply_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |-> !drv_en_o);

  // R8
  therm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    therm_flt_i |-> !drv_en_o);
endmodule

bind hb_restart_seq hb_restart_seq_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .supply_ok_i(supply_ok_i),
  .therm_flt_i(therm_flt_i),
  .drv_en_o   (drv_en_o),
  .bo_sink_o  (bo_sink_o),
  .osc_hold_o (osc_hold_o),
  .bo_ok_o    (bo_ok_o),
  .bo_flt     (bo_flt),
  .en_flt     (en_flt)
);

// File: tb/test_hb_restart_seq.sv
module test_hb_restart_seq;
  localparam int unsigned BENCH_HZ = 100_000;
  localparam int WDOG = 190_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sup = '0, bor = '0, enr = '0, thr = '0;
  logic [1:0] drv, snk, hld, bok;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hb_restart_seq #(.CLK_HZ(BENCH_HZ), .SHORT_VAR(1'b0)) i_hb_restart_seq (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(sup[0]), .bo_cmp_i(bor[0]),
    .en_cmp_i(enr[0]), .therm_flt_i(thr[0]), .drv_en_o(drv[0]),
    .bo_sink_o(snk[0]), .osc_hold_o(hld[0]), .bo_ok_o(bok[0]));

  hb_restart_seq #(.CLK_HZ(BENCH_HZ), .SHORT_VAR(1'b1)) i_hb_restart_seq_s (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(sup[1]), .bo_cmp_i(bor[1]),
    .en_cmp_i(enr[1]), .therm_flt_i(thr[1]), .drv_en_o(drv[1]),
    .bo_sink_o(snk[1]), .osc_hold_o(hld[1]), .bo_ok_o(bok[1]));

  // expected lengths from the millisecond figures
  function automatic int win_of(int v);
    return v ? int'(BENCH_HZ * 63 / 10000) : int'(BENCH_HZ * 50 / 1000);
  endfunction
  function automatic int dly_of(int v);
    return v ? int'(BENCH_HZ * 126 / 10000) : int'(BENCH_HZ / 10);
  endfunction
  localparam int BF = int'(BENCH_HZ * 20 / 1_000_000);
  localparam int EF = (BENCH_HZ / 2_000_000 == 0) ? 1 : int'(BENCH_HZ / 2_000_000);

  function automatic logic sig(int v, int w);
    case (w)
      0: return drv[v];
      1: return snk[v];
      2: return hld[v];
      default: return bok[v];
    endcase
  endfunction

  task automatic check(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // posedges until signal w of copy v changes
  task automatic count_edges(input int v, input int w, input int lim, output int n);
    logic s0;
    s0 = sig(v, w);
    n = 0;
    while (n < lim) begin
      @(posedge clk); #1;
      n++;
      if (sig(v, w) != s0) break;
    end
  endtask

  task automatic suite(input int v);
    int n;
    int w;
    int d;
    w = win_of(v);
    d = dly_of(v);
    // normal start
    @(negedge clk); bor[v] = 1'b1; sup[v] = 1'b1;
    count_edges(v, 1, w + 10, n);
    check("R1 sink window", n, w + 1);
    check("R6 bo_ok in delay", bok[v], 1);
    check("R5 hold in delay", hld[v], 1);
    count_edges(v, 0, d + 10, n);
    check("R4 restart delay", n, d);
    check("R5 hold released", hld[v], 0);
    // stop input
    @(negedge clk); enr[v] = 1'b1;
    count_edges(v, 0, 20, n);
    check("R7 stop drop", n, EF);
    check("R7 hold stays low", hld[v], 0);
    @(negedge clk); enr[v] = 1'b0;
    count_edges(v, 0, 20, n);
    check("R7 resume no delay", n, EF);
    // thermal
    @(negedge clk); thr[v] = 1'b1; #1;
    check("R8 thermal off", drv[v], 0);
    @(negedge clk); thr[v] = 1'b0; #1;
    check("R8 thermal clear", drv[v], 1);
    // short glitch on bulk comparator
    @(negedge clk); bor[v] = 1'b0;
    repeat (BF - 1) @(negedge clk);
    bor[v] = 1'b1;
    repeat (6) @(negedge clk);
    check("R3 glitch ignored", drv[v], 1);
    // brown-out while running
    bor[v] = 1'b0;
    count_edges(v, 0, 20, n);
    check("R10 brownout drop", n, BF + 1);
    check("R10 sink on", snk[v], 1);
    check("R10 bo_ok low", bok[v], 0);
    repeat (w + 20) @(negedge clk);
    check("R2 sink held", snk[v], 1);
    bor[v] = 1'b1;
    count_edges(v, 1, 20, n);
    check("R3 recovery filter", n, BF + 1);
    count_edges(v, 0, d + 10, n);
    check("R10 delay only", n, d);
    // supply loss
    @(negedge clk); sup[v] = 1'b0; #1;
    check("R8 supply off", drv[v], 0);
    @(posedge clk); #1;
    check("R8 sink after loss", snk[v], 1);
    check("R8 bo_ok after loss", bok[v], 0);
    // abort during delay
    @(negedge clk); sup[v] = 1'b1;
    count_edges(v, 1, w + 10, n);
    check("R1 second window", n, w + 1);
    repeat (5) @(negedge clk);
    bor[v] = 1'b0;
    count_edges(v, 1, 20, n);
    check("R9 abort sink", n, BF + 1);
    @(negedge clk); bor[v] = 1'b1;
    count_edges(v, 0, w + d + 10, n);
    check("R9 full restart", n, w + d);
    // start with bulk low
    @(negedge clk); sup[v] = 1'b0; bor[v] = 1'b0;
    repeat (BF + 3) @(negedge clk);
    sup[v] = 1'b1;
    repeat (w + 20) @(negedge clk);
    check("R2 sink kept", snk[v], 1);
    check("R2 bo_ok low", bok[v], 0);
    check("R2 drive low", drv[v], 0);
    bor[v] = 1'b1;
    count_edges(v, 1, 20, n);
    check("R2 late bulk", n, BF + 1);
    count_edges(v, 0, d + 10, n);
    check("R4 delay after late bulk", n, d);
    @(negedge clk); sup[v] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int v = 0; v < 2; v++) begin
      check("R11 drv reset", drv[v], 0);
      check("R11 sink reset", snk[v], 1);
      check("R11 hold reset", hld[v], 1);
      check("R11 ok reset", bok[v], 0);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int v = 0; v < 2; v++) begin
      check("R11 drv after reset", drv[v], 0);
      check("R11 sink after reset", snk[v], 1);
    end
    suite(0);
    suite(1);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", WDOG, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule